// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the processor status word (execution-state bit, two interrupt mask bits and a three-bit mode field) and keeps one saved copy of that word for each exception mode. When one or more exception requests arrive, it picks the winner by a fixed priority. It then performs the whole entry sequence in a single clock edge. The return address goes to the new mode's link register through a write port to the register file. The old status word is parked in the new mode's save slot. The mode changes, the masks and state bit are adjusted, and the program counter is redirected to the exception's vector.

It also performs the return operation. The saved word of the current exception mode is copied back into the live status word, and the program counter is loaded with the link value minus 4 or minus 8. Privileged software may rewrite the mode field. Any code may flip the execution-state bit. All outputs are registered, so every effect appears in the cycle after the edge that accepted the operation.

Top module: `trapctl_top`

## Requirements
- R1: While `rst_n` is low, and after it, the status word reads supervisor mode with I=1, F=1 and T=0, and `pc_load` and `lr_we` are 0.
- R2: The status word is {T, F, I, mode[2:0]}. Mode codes: user 0, fast interrupt 1, interrupt 2, supervisor 3, abort 4, undefined 5, system 7. Code 6 is unused. With no operation requested, the status word holds.
- R3: On the cycle after an exception is accepted, `lr_we`=1, `lr_mode` is the new mode and `lr_data` equals the `next_pc` presented with the request. `lr_we` is never 1 without `pc_load`.
- R4: Accepting an exception stores the pre-entry status word in the save slot of the new mode. A later return from that mode restores exactly that word.
- R5: Exception entry sets the mode to the request's mode, loads `pc_target` with VEC_BASE plus the vector offset, clears T and sets I. Reset request and fast interrupt also set F. Modes and vector offsets are: reset→supervisor 0x00, undefined→undefined 0x04, call→supervisor 0x08, prefetch abort→abort 0x0C, data abort→abort 0x10, interrupt→interrupt 0x18, fast interrupt→fast 0x1C.
- R6: Among simultaneous requests the winner is reset, then data abort, then fast interrupt, then interrupt, then prefetch abort, then undefined, then call.
- R7: An interrupt request is ignored while I=1, and a fast interrupt request is ignored while F=1.
- R8: A return in an exception mode loads the status word from that mode's slot and pulses `pc_load` with `pc_target` = `lr_rdata` − 8 when `ret_sub8`=1, else − 4.
- R9: A return requested in user or system mode changes nothing: no `pc_load`, and the status word holds.
- R10: A mode write takes effect on the next cycle only when the current mode is not user and the new code is not 6. Otherwise it is ignored.
- R11: A state write changes only T. Mode, I and F hold.
- R12: Operations are taken in this order: exception, then return, then mode write, then state write. A lower one is dropped whenever a higher one's input is asserted, even if that higher one is itself ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_call | input | 1 | Software call request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| next_pc | input | AW | Address of the next instruction of the interrupted code |
| ret_valid | input | 1 | Return-with-restore request |
| ret_sub8 | input | 1 | Return offset select: 1 subtracts 8, 0 subtracts 4 |
| lr_rdata | input | AW | Current mode's link register value |
| sw_mode_we | input | 1 | Software mode write strobe |
| sw_mode | input | 3 | Requested mode code |
| state_we | input | 1 | Execution-state write strobe |
| state_thumb | input | 1 | New T value |
| cur_mode | output | 3 | Current mode code |
| t_bit | output | 1 | Execution state: 1 half-word instructions, 0 word instructions |
| i_bit | output | 1 | Interrupt mask |
| f_bit | output | 1 | Fast interrupt mask |
| pc_load | output | 1 | Program counter redirect pulse |
| pc_target | output | AW | Redirect address |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 3 | Mode whose link register is written |
| lr_data | output | AW | Value written to the link register |

## Verification
The bench drives all seven requests together and in pairs. A broken priority chain would show up here as the wrong vector or a wrong mode. Interrupts are raised while masked. A design that ignored the mask bits would redirect into the interrupt mode when it should hold still. Returns are issued in user and system modes, where a design with no guard would read a save slot that does not exist and corrupt the status word. Mode writes are issued from user mode and with the unused code 6, together with mixed strobes. These cases catch a missing privilege check and a wrong precedence order, which would leak a dropped operation into the state.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;

  typedef enum logic [2:0] {
    M_USER   = 3'd0,
    M_FAST   = 3'd1,
    M_INTR   = 3'd2,
    M_SUPER  = 3'd3,
    M_ABORT  = 3'd4,
    M_UNDEF  = 3'd5,
    M_SYSTEM = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_RESET = 3'd1,
    K_DABT  = 3'd2,
    K_FAST  = 3'd3,
    K_INTR  = 3'd4,
    K_PABT  = 3'd5,
    K_UNDEF = 3'd6,
    K_CALL  = 3'd7
  } kind_e;

  typedef struct packed {
    logic  thumb;
    logic  fmask;
    logic  imask;
    mode_e mode;
  } stat_t;

  localparam int NUM_SLOTS = 5;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  localparam stat_t RESET_STAT = '{thumb: 1'b0, fmask: 1'b1, imask: 1'b1, mode: M_SUPER};

  // byte offset of each exception's vector
  function automatic logic [7:0] vec_off(kind_e k);
    case (k)
      K_UNDEF: return 8'h04;
      K_CALL:  return 8'h08;
      K_PABT:  return 8'h0C;
      K_DABT:  return 8'h10;
      K_INTR:  return 8'h18;
      K_FAST:  return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic mode_e mode_for(kind_e k);
    case (k)
      K_DABT, K_PABT: return M_ABORT;
      K_FAST:         return M_FAST;
      K_INTR:         return M_INTR;
      K_UNDEF:        return M_UNDEF;
      default:        return M_SUPER;
    endcase
  endfunction

  function automatic logic has_slot(mode_e m);
    return (m != M_USER) && (m != M_SYSTEM);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(mode_e m);
    case (m)
      M_INTR:  return SLOT_W'(1);
      M_SUPER: return SLOT_W'(2);
      M_ABORT: return SLOT_W'(3);
      M_UNDEF: return SLOT_W'(4);
      default: return SLOT_W'(0);
    endcase
  endfunction

  function automatic logic mode_code_ok(logic [2:0] c);
    return c != 3'd6;
  endfunction

  function automatic stat_t entry_status(stat_t cur, kind_e k);
    stat_t n;
    n       = cur;
    n.mode  = mode_for(k);
    n.thumb = 1'b0;
    n.imask = 1'b1;
    if (k == K_FAST || k == K_RESET) n.fmask = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/trapctl_arb.sv
module trapctl_arb
  import trapctl_pkg::*;
(
  input  logic  req_reset,
  input  logic  req_undef,
  input  logic  req_call,
  input  logic  req_pabt,
  input  logic  req_dabt,
  input  logic  req_irq,
  input  logic  req_fiq,
  input  logic  imask,
  input  logic  fmask,
  output logic  take,
  output kind_e kind
);
  logic irq_open, fiq_open;
  assign irq_open = req_irq && !imask;
  assign fiq_open = req_fiq && !fmask;

  always_comb begin
    if (req_reset)      kind = K_RESET;
    else if (req_dabt)  kind = K_DABT;
    else if (fiq_open)  kind = K_FAST;
    else if (irq_open)  kind = K_INTR;
    else if (req_pabt)  kind = K_PABT;
    else if (req_undef) kind = K_UNDEF;
    else if (req_call)  kind = K_CALL;
    else                kind = K_NONE;
  end

  assign take = (kind != K_NONE);
endmodule

// File: rtl/trapctl_bank.sv
module trapctl_bank
  import trapctl_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  parameter int SW    = SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  stat_t         wr_data,
  input  logic [SW-1:0] rd_slot,
  output stat_t         rd_data
);
  stat_t slot_q [SLOTS];

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      stat_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && (wr_slot == SW'(g)))     q <= wr_data;
      end
      assign slot_q[g] = q;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SLOTS; s++)
      if (rd_slot == SW'(s)) rd_data = slot_q[s];
  end
endmodule

// File: rtl/trapctl_status.sv
module trapctl_status
  import trapctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  do_entry,
  input  stat_t entry_val,
  input  logic  do_ret,
  input  stat_t ret_val,
  input  logic  do_mwr,
  input  mode_e mwr_mode,
  input  logic  do_twr,
  input  logic  twr_thumb,
  output stat_t cur
);
  stat_t nxt;

  always_comb begin
    nxt = cur;
    if (do_entry)    nxt = entry_val;
    else if (do_ret) nxt = ret_val;
    else if (do_mwr) nxt.mode = mwr_mode;
    else if (do_twr) nxt.thumb = twr_thumb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= RESET_STAT;
    else        cur <= nxt;
  end
endmodule

// File: rtl/trapctl_top.sv
module trapctl_top
  import trapctl_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_reset,
  input  logic          req_undef,
  input  logic          req_call,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic [AW-1:0] next_pc,
  input  logic          ret_valid,
  input  logic          ret_sub8,
  input  logic [AW-1:0] lr_rdata,
  input  logic          sw_mode_we,
  input  logic [2:0]    sw_mode,
  input  logic          state_we,
  input  logic          state_thumb,
  output logic [2:0]    cur_mode,
  output logic          t_bit,
  output logic          i_bit,
  output logic          f_bit,
  output logic          pc_load,
  output logic [AW-1:0] pc_target,
  output logic          lr_we,
  output logic [2:0]    lr_mode,
  output logic [AW-1:0] lr_data
);
  localparam logic [AW-1:0] SUB_SHORT = AW'(4);
  localparam logic [AW-1:0] SUB_LONG  = AW'(8);

  function automatic logic [AW-1:0] ret_target(logic [AW-1:0] lr, logic long_sub);
    return lr - (long_sub ? SUB_LONG : SUB_SHORT);
  endfunction

  function automatic logic [AW-1:0] vec_addr(kind_e k);
    return VEC_BASE + AW'(vec_off(k));
  endfunction

  // named internal events
  stat_t cur_q, entry_val, saved_rd;
  kind_e take_kind;
  logic  take_exc, do_ret, do_mwr, do_twr;
  mode_e tgt_mode;

  trapctl_arb u_arb (
    .req_reset (req_reset),
    .req_undef (req_undef),
    .req_call  (req_call),
    .req_pabt  (req_pabt),
    .req_dabt  (req_dabt),
    .req_irq   (req_irq),
    .req_fiq   (req_fiq),
    .imask     (cur_q.imask),
    .fmask     (cur_q.fmask),
    .take      (take_exc),
    .kind      (take_kind)
  );

  assign tgt_mode  = mode_for(take_kind);
  assign entry_val = entry_status(cur_q, take_kind);

  assign do_ret = ret_valid && !take_exc && has_slot(cur_q.mode);
  assign do_mwr = sw_mode_we && !take_exc && !ret_valid &&
                  (cur_q.mode != M_USER) && mode_code_ok(sw_mode);
  assign do_twr = state_we && !take_exc && !ret_valid && !sw_mode_we;

  trapctl_bank #(.SLOTS(NUM_SLOTS), .SW(SLOT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take_exc),
    .wr_slot (slot_of(tgt_mode)),
    .wr_data (cur_q),
    .rd_slot (slot_of(cur_q.mode)),
    .rd_data (saved_rd)
  );

  trapctl_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_entry  (take_exc),
    .entry_val (entry_val),
    .do_ret    (do_ret),
    .ret_val   (saved_rd),
    .do_mwr    (do_mwr),
    .mwr_mode  (mode_e'(sw_mode)),
    .do_twr    (do_twr),
    .twr_thumb (state_thumb),
    .cur       (cur_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load   <= 1'b0;
      pc_target <= '0;
      lr_we     <= 1'b0;
      lr_mode   <= 3'd0;
      lr_data   <= '0;
    end else begin
      pc_load <= take_exc || do_ret;
      lr_we   <= take_exc;
      if (take_exc) begin
        pc_target <= vec_addr(take_kind);
        lr_mode   <= tgt_mode;
        lr_data   <= next_pc;
      end else if (do_ret) begin
        pc_target <= ret_target(lr_rdata, ret_sub8);
      end
    end
  end

  assign cur_mode = cur_q.mode;
  assign t_bit    = cur_q.thumb;
  assign i_bit    = cur_q.imask;
  assign f_bit    = cur_q.fmask;
endmodule

// File: rtl/trapctl_chk.sv
module trapctl_chk
  import trapctl_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_reset,
  input logic          req_undef,
  input logic          req_call,
  input logic          req_pabt,
  input logic          req_dabt,
  input logic          req_irq,
  input logic          req_fiq,
  input logic [AW-1:0] next_pc,
  input logic          ret_valid,
  input logic          sw_mode_we,
  input logic          state_we,
  input logic [2:0]    cur_mode,
  input logic          t_bit,
  input logic          i_bit,
  input logic          f_bit,
  input logic          pc_load,
  input logic          lr_we,
  input logic [2:0]    lr_mode,
  input logic [AW-1:0] lr_data,
  input logic          take_exc,
  input logic [2:0]    take_kind
);
  logic others_quiet;
  assign others_quiet = !req_reset && !req_dabt && !(req_fiq && !f_bit) &&
                        !req_pabt && !req_undef && !req_call;

  assert_entry_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> lr_we && (lr_data == $past(next_pc)) && (lr_mode == cur_mode));

  assert_link_pairs_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> pc_load);

  assert_entry_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> pc_load && !t_bit && i_bit &&
                 (cur_mode == 3'(mode_for(kind_e'($past(take_kind))))));

  assert_fast_sets_f_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && (take_kind == 3'(K_FAST) || take_kind == 3'(K_RESET))) |=> f_bit);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && i_bit && others_quiet && !ret_valid) |=> !pc_load);

  assert_ret_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !take_exc && (cur_mode == 3'd0 || cur_mode == 3'd7))
      |=> !pc_load && $stable(cur_mode) && $stable(i_bit));

  assert_user_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode_we && cur_mode == 3'd0 && !take_exc && !ret_valid) |=> cur_mode == 3'd0);

  assert_state_only_t_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_we && !take_exc && !ret_valid && !sw_mode_we)
      |=> $stable(cur_mode) && $stable(i_bit) && $stable(f_bit));
endmodule

bind trapctl_top trapctl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_reset  (req_reset),
  .req_undef  (req_undef),
  .req_call   (req_call),
  .req_pabt   (req_pabt),
  .req_dabt   (req_dabt),
  .req_irq    (req_irq),
  .req_fiq    (req_fiq),
  .next_pc    (next_pc),
  .ret_valid  (ret_valid),
  .sw_mode_we (sw_mode_we),
  .state_we   (state_we),
  .cur_mode   (cur_mode),
  .t_bit      (t_bit),
  .i_bit      (i_bit),
  .f_bit      (f_bit),
  .pc_load    (pc_load),
  .lr_we      (lr_we),
  .lr_mode    (lr_mode),
  .lr_data    (lr_data),
  .take_exc   (take_exc),
  .take_kind  (take_kind)
);

// File: tb/trapctl_top_tb.sv
module trapctl_top_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_reset = 0, req_undef = 0, req_call = 0, req_pabt = 0;
  logic req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic [AW-1:0] next_pc = '0, lr_rdata = '0;
  logic ret_valid = 0, ret_sub8 = 0, sw_mode_we = 0, state_we = 0, state_thumb = 0;
  logic [2:0] sw_mode = '0;
  logic [2:0] cur_mode, lr_mode;
  logic t_bit, i_bit, f_bit, pc_load, lr_we;
  logic [AW-1:0] pc_target, lr_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [2:0] m_mode;
  logic m_t, m_i, m_f;
  logic [5:0] m_saved [8];
  logic e_pc_load, e_lr_we;
  logic [AW-1:0] e_pc, e_lr_data;
  logic [2:0] e_lr_mode;

  always #10 clk = ~clk;

  trapctl_top #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req_reset), .req_undef(req_undef), .req_call(req_call),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .next_pc(next_pc), .ret_valid(ret_valid), .ret_sub8(ret_sub8), .lr_rdata(lr_rdata),
    .sw_mode_we(sw_mode_we), .sw_mode(sw_mode), .state_we(state_we),
    .state_thumb(state_thumb), .cur_mode(cur_mode), .t_bit(t_bit), .i_bit(i_bit),
    .f_bit(f_bit), .pc_load(pc_load), .pc_target(pc_target), .lr_we(lr_we),
    .lr_mode(lr_mode), .lr_data(lr_data)
  );

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] m_word();
    return {m_t, m_f, m_i, m_mode};
  endfunction

  task automatic clear_in();
    {req_reset, req_undef, req_call, req_pabt, req_dabt, req_irq, req_fiq} = '0;
    {ret_valid, ret_sub8, sw_mode_we, state_we, state_thumb} = '0;
    sw_mode = '0;
  endtask

  // compute expectation from present inputs, clock once, compare
  task automatic step();
    string st_tag, pc_tag;
    bit take;
    logic [2:0] nm;
    logic [7:0] vo;
    bit setf;
    int nreq, nops;
    take = 1; setf = 0; nm = 3'd3; vo = 8'h00;
    nreq = int'(req_reset) + int'(req_dabt) + int'(req_fiq) + int'(req_irq) +
           int'(req_pabt) + int'(req_undef) + int'(req_call);
    nops = int'(ret_valid) + int'(sw_mode_we) + int'(state_we);
    if (req_reset)                begin nm = 3'd3; vo = 8'h00; setf = 1; end
    else if (req_dabt)            begin nm = 3'd4; vo = 8'h10; end
    else if (req_fiq && !m_f)     begin nm = 3'd1; vo = 8'h1C; setf = 1; end
    else if (req_irq && !m_i)     begin nm = 3'd2; vo = 8'h18; end
    else if (req_pabt)            begin nm = 3'd4; vo = 8'h0C; end
    else if (req_undef)           begin nm = 3'd5; vo = 8'h04; end
    else if (req_call)            begin nm = 3'd3; vo = 8'h08; end
    else take = 0;
    e_pc_load = 0; e_lr_we = 0;
    st_tag = "R2"; pc_tag = "R2";
    if (take) begin
      st_tag = (nreq > 1) ? "R6" : "R5";
      pc_tag = st_tag;
      m_saved[nm] = m_word();
      e_lr_we = 1; e_lr_mode = nm; e_lr_data = next_pc;
      e_pc_load = 1; e_pc = AW'(vo);
      m_mode = nm; m_t = 0; m_i = 1;
      if (setf) m_f = 1;
    end else begin
      if (nreq > 0) st_tag = "R7";
      if (nops > 1) st_tag = "R12";
      if (ret_valid) begin
        if (m_mode != 3'd0 && m_mode != 3'd7) begin
          {m_t, m_f, m_i, m_mode} = m_saved[m_mode];
          e_pc_load = 1; e_pc = lr_rdata - (ret_sub8 ? 8 : 4);
          if (nops == 1) st_tag = "R4";
          pc_tag = "R8";
        end else begin
          if (nops == 1) st_tag = "R9";
          pc_tag = "R9";
        end
      end else if (sw_mode_we) begin
        if (nops == 1) st_tag = "R10";
        if (m_mode != 3'd0 && sw_mode != 3'd6) m_mode = sw_mode;
      end else if (state_we) begin
        st_tag = "R11";
        m_t = state_thumb;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({t_bit, f_bit, i_bit, cur_mode} == m_word(), st_tag, "status",
        64'({t_bit, f_bit, i_bit, cur_mode}), 64'(m_word()));
    chk(pc_load == e_pc_load, pc_tag, "pc_load", 64'(pc_load), 64'(e_pc_load));
    if (e_pc_load)
      chk(pc_target == e_pc, pc_tag, "pc_target", 64'(pc_target), 64'(e_pc));
    chk(lr_we == e_lr_we, "R3", "lr_we", 64'(lr_we), 64'(e_lr_we));
    if (e_lr_we) begin
      chk(lr_data == e_lr_data, "R3", "lr_data", 64'(lr_data), 64'(e_lr_data));
      chk(lr_mode == e_lr_mode, "R3", "lr_mode", 64'(lr_mode), 64'(e_lr_mode));
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    m_mode = 3'd3; m_t = 0; m_i = 1; m_f = 1;
    for (int k = 0; k < 8; k++) m_saved[k] = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk({t_bit, f_bit, i_bit, cur_mode} == 6'b011011, "R1", "reset status",
        64'({t_bit, f_bit, i_bit, cur_mode}), 64'h1B);
    chk(!pc_load && !lr_we, "R1", "reset strobes", 64'({pc_load, lr_we}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk({t_bit, f_bit, i_bit, cur_mode} == 6'b011011, "R1", "after release",
        64'({t_bit, f_bit, i_bit, cur_mode}), 64'h1B);

    // R8: return from supervisor restores the cleared slot (user, unmasked)
    clear_in(); ret_valid = 1; lr_rdata = 32'h100; step();
    // R10: mode write from user ignored
    clear_in(); sw_mode_we = 1; sw_mode = 3'd3; step();
    // R11: state write
    clear_in(); state_we = 1; state_thumb = 1; step();
    // R5/R3: interrupt entry
    clear_in(); req_irq = 1; next_pc = 32'h0000_2468; step();
    // R7: masked interrupt
    clear_in(); req_irq = 1; next_pc = 32'h0000_3000; step();
    // R6: fast beats masked interrupt and abort lower
    clear_in(); req_fiq = 1; req_pabt = 1; req_call = 1; next_pc = 32'h0000_4004; step();
    // R8 with sub8: back to interrupt mode
    clear_in(); ret_valid = 1; ret_sub8 = 1; lr_rdata = 32'h0000_4004; step();
    // R10: privileged write to system, then R9 return ignored
    clear_in(); sw_mode_we = 1; sw_mode = 3'd7; step();
    clear_in(); ret_valid = 1; lr_rdata = 32'h55; step();
    // R10: unused code 6 ignored
    clear_in(); sw_mode_we = 1; sw_mode = 3'd6; step();
    // R12: return (ignored in system) still blocks mode write
    clear_in(); ret_valid = 1; sw_mode_we = 1; sw_mode = 3'd4; state_we = 1; step();
    // R6: every request at once, reset wins
    clear_in(); {req_reset, req_undef, req_call, req_pabt, req_dabt, req_irq, req_fiq} = '1;
    next_pc = 32'hABCD_0000; step();
    // R6: data abort beats the rest
    clear_in(); {req_undef, req_call, req_pabt, req_dabt} = '1; next_pc = 32'h10; step();

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      clear_in();
      r = $urandom;
      req_reset  = (r[5:0] == 6'd0);
      req_dabt   = (r[8:6] == 3'd0);
      req_fiq    = (r[11:9] == 3'd0);
      req_irq    = (r[14:12] == 3'd0);
      req_pabt   = (r[17:15] == 3'd0);
      req_undef  = (r[20:18] == 3'd0);
      req_call   = (r[23:21] == 3'd0);
      ret_valid  = (r[26:24] < 3'd2);
      ret_sub8   = r[27];
      sw_mode_we = (r[29:28] == 2'd0);
      state_we   = (r[31:30] == 2'd0);
      r = $urandom;
      sw_mode     = r[2:0];
      state_thumb = r[3];
      next_pc  = $urandom & 32'hFFFF_FFFC;
      lr_rdata = $urandom;
      step();
    end
    clear_in();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule